// File: doc/BRIEF.md
# Balanced-Ternary Five-Trit Instruction Executor

This block is a small balanced-ternary register machine. Each instruction word holds five trits. The two upper trits form an opcode in the range −4..+4, and the three lower trits form a signed argument in the range −13..+13. The machine holds thirteen three-trit registers, numbered 1 to 13, a one-trit sign flag and a three-trit program offset. It fetches from an internal synchronous instruction store. The fetch address is six trits: register 13 supplies the segment trits and the program offset supplies the in-segment trits.

Five things are decoded from the word:
- Positive opcodes load the argument into registers 1..4.
- Opcode 0 is the transfer group. The sign and magnitude of its argument pick the register and the direction of a copy through register 1. The same group also holds increment, decrement and test of register 1.
- Opcode −3 replaces the program offset.
- Opcodes −1 and −2 are treated as no-ops.
- Opcode −4 is reserved and is also treated as a no-op.

The store is loaded through a write port while the machine is held in reset. Execution starts when reset is released. Each instruction takes two clock cycles: a fetch cycle, then an execute cycle.

Top module: `tern_exec`

## Requirements
- R1: While reset is low and in the first cycle after it is released, all registers read 0, `flag_o` is 0, `exec_o` is 0 and `pc_o` is segment 0, offset −13.
- R2: Cycles after reset alternate between fetch (`exec_o` low) and execute (`exec_o` high), starting with fetch. The word at `pc_o` during the fetch cycle is the one that takes effect at the end of the following execute cycle.
- R3: The opcode value is 3·(bits [9:8]) + (bits [7:6]), read as trits. The argument is bits [5:0], read as trits with weights 9, 3 and 1 from the top down. Opcodes +1..+4 write the argument into registers 1..4.
- R4: With opcode 0, argument −k (k = 2..13) copies register 1 into register k, and argument +k copies register k into register 1. Neither copy changes the flag.
- R5: With opcode 0, argument +1 increments register 1 and argument −1 decrements it. The result wraps within −13..+13, so +13 becomes −13 and −13 becomes +13. The flag takes the sign of the result.
- R6: With opcode 0 and argument 0, register 1 is unchanged and the flag takes its sign.
- R7: Opcode −3 sets the program offset to the argument and leaves the segment unchanged.
- R8: Every other instruction advances the offset by one, with +13 wrapping to −13 inside the same segment.
- R9: The fetch segment is always the current value of register 13. A write to register 13 takes effect at the next fetch.
- R10: Opcodes −1, −2 and −4 change no register and no flag. They only advance the offset.
- R11: A trit is coded 2'b10 for −1, 2'b00 for 0 and 2'b01 for +1. The code 2'b11 in an instruction is read as 0. Outputs carry only the three legal codes.
- R12: A word written with `imem_we_i` at a six-trit address (segment in [11:6], offset in [5:0]) is the word fetched at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction store write strobe |
| imem_addr_i | input | 12 | Write address: segment trits [11:6], offset trits [5:0] |
| imem_data_i | input | 10 | Instruction word to store |
| exec_o | output | 1 | High during an execute cycle |
| pc_o | output | 12 | Fetch address: register 13 in [11:6], program offset in [5:0] |
| r1_o | output | 6 | Register 1 value |
| flag_o | output | 2 | Sign flag trit |

## Verification
A corrupted offset or segment shows on `pc_o` at the very next fetch. Because the fetch address feeds the store, it also sends every later instruction down the wrong path. A wrong copy or load shows on `r1_o` only when a later instruction brings that register back into register 1. The test programs therefore read every written register back within a few instructions. A wrong flag shows on `flag_o` in the cycle after an increment, a decrement or a test.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int TRITS    = 3;
  localparam int OP_TRITS = 2;
  localparam int TW       = 2 * TRITS;
  localparam int IW       = 2 * (TRITS + OP_TRITS);
  localparam int TMAX     = (3 ** TRITS - 1) / 2;
  localparam int TRANGE   = 3 ** TRITS;
  localparam int NREG     = TMAX;
  localparam int RAW      = $clog2(NREG + 1);
  localparam int OP_JUMP  = -3;

  typedef logic [1:0]    trit_t;
  typedef logic [TW-1:0] triad_t;
  typedef logic [IW-1:0] instr_t;

  typedef enum logic [2:0] {
    K_NOP, K_LOAD, K_COPY_TO, K_COPY_FROM, K_INC, K_DEC, K_TEST, K_JUMP
  } kind_e;

  typedef struct packed {
    kind_e          kind;
    logic [RAW-1:0] idx;
    triad_t         arg;
  } ctrl_t;

  function automatic int trit_val(trit_t t);
    case (t)
      2'b01:   return 1;
      2'b10:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int triad_val(triad_t x);
    int v;
    v = 0;
    for (int i = TRITS - 1; i >= 0; i--) v = v * 3 + trit_val(x[2*i +: 2]);
    return v;
  endfunction

  function automatic trit_t trit_enc(int v);
    if (v > 0) return 2'b01;
    if (v < 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic triad_t triad_enc(int v);
    triad_t r;
    int u;
    r = '0;
    u = v + TMAX;
    for (int i = 0; i < TRITS; i++) begin
      r[2*i +: 2] = trit_enc((u % 3) - 1);
      u = u / 3;
    end
    return r;
  endfunction

  function automatic int wrap_add(int v, int d);
    int s;
    s = v + d;
    if (s > TMAX) s = s - TRANGE;
    else if (s < -TMAX) s = s + TRANGE;
    return s;
  endfunction

  function automatic int op_val(instr_t w);
    return 3 * trit_val(w[IW-1 -: 2]) + trit_val(w[IW-3 -: 2]);
  endfunction

  localparam triad_t OFF_START = triad_enc(-TMAX);
endpackage

// File: rtl/tern_imem.sv
module tern_imem
  import tern_pkg::*;
(
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [2*TW-1:0] waddr_i,
  input  instr_t         wdata_i,
  input  logic [2*TW-1:0] raddr_i,
  output instr_t         rdata_o
);
  localparam int DEPTH = TRANGE * TRANGE;
  localparam int AW    = $clog2(DEPTH);

  function automatic logic [AW-1:0] lin(logic [2*TW-1:0] a);
    return AW'((triad_val(a[2*TW-1 -: TW]) + TMAX) * TRANGE
               + triad_val(a[TW-1:0]) + TMAX);
  endfunction

  instr_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[lin(waddr_i)] <= wdata_i;
    rdata_o <= mem[lin(raddr_i)];
  end
endmodule

// File: rtl/tern_decode.sv
module tern_decode
  import tern_pkg::*;
(
  input  instr_t instr_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    int op_v;
    int k_v;
    op_v = op_val(instr_i);
    k_v  = triad_val(instr_i[TW-1:0]);
    ctrl_o.kind = K_NOP;
    ctrl_o.idx  = RAW'(1);
    ctrl_o.arg  = triad_enc(k_v);  // canonical: illegal codes become 0
    if (op_v >= 1) begin
      ctrl_o.kind = K_LOAD;
      ctrl_o.idx  = RAW'(op_v);
    end else if (op_v == 0) begin
      if (k_v <= -2) begin
        ctrl_o.kind = K_COPY_TO;
        ctrl_o.idx  = RAW'(-k_v);
      end else if (k_v >= 2) begin
        ctrl_o.kind = K_COPY_FROM;
        ctrl_o.idx  = RAW'(k_v);
      end else if (k_v == 1) begin
        ctrl_o.kind = K_INC;
      end else if (k_v == -1) begin
        ctrl_o.kind = K_DEC;
      end else begin
        ctrl_o.kind = K_TEST;
      end
    end else if (op_v == OP_JUMP) begin
      ctrl_o.kind = K_JUMP;
    end
  end
endmodule

// File: rtl/tern_regfile.sv
module tern_regfile
  import tern_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  triad_t         wdata_i,
  input  logic [RAW-1:0] raddr_i,
  output triad_t         rdata_o,
  output triad_t         r1_o,
  output triad_t         seg_o
);
  triad_t regs [1:NREG];

  for (genvar g = 1; g <= NREG; g++) begin : g_reg
    triad_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && waddr_i == RAW'(g)) q <= wdata_i;
    end
    assign regs[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 1; i <= NREG; i++) if (raddr_i == RAW'(i)) rdata_o = regs[i];
  end

  assign r1_o  = regs[1];
  assign seg_o = regs[NREG];
endmodule

// File: rtl/tern_alu.sv
module tern_alu
  import tern_pkg::*;
(
  input  triad_t r1_i,
  input  logic   dec_i,
  input  logic   test_i,
  output triad_t res_o,
  output trit_t  sign_o
);
  always_comb begin
    int v;
    int s;
    v      = triad_val(r1_i);
    s      = wrap_add(v, dec_i ? -1 : 1);
    res_o  = triad_enc(s);
    sign_o = trit_enc(test_i ? v : s);
  end
endmodule

// File: rtl/tern_exec.sv
module tern_exec
  import tern_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           imem_we_i,
  input  logic [11:0]    imem_addr_i,
  input  logic [9:0]     imem_data_i,
  output logic           exec_o,
  output logic [11:0]    pc_o,
  output logic [5:0]     r1_o,
  output logic [1:0]     flag_o
);
  logic   phase_q;
  triad_t off_q;
  trit_t  flag_q;
  instr_t instr_q;
  ctrl_t  ctrl;
  triad_t r1, seg, rf_rdata, rf_wdata, alu_res;
  trit_t  alu_sign;
  logic   rf_we;
  logic [RAW-1:0] rf_waddr;

  tern_imem u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_addr_i),
    .wdata_i (imem_data_i),
    .raddr_i ({seg, off_q}),
    .rdata_o (instr_q)
  );

  tern_decode u_dec (.instr_i(instr_q), .ctrl_o(ctrl));

  tern_alu u_alu (
    .r1_i   (r1),
    .dec_i  (ctrl.kind == K_DEC),
    .test_i (ctrl.kind == K_TEST),
    .res_o  (alu_res),
    .sign_o (alu_sign)
  );

  tern_regfile u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (ctrl.idx),
    .rdata_o (rf_rdata),
    .r1_o    (r1),
    .seg_o   (seg)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = RAW'(1);
    rf_wdata = alu_res;
    if (phase_q) begin
      unique case (ctrl.kind)
        K_LOAD: begin
          rf_we = 1'b1; rf_waddr = ctrl.idx; rf_wdata = ctrl.arg;
        end
        K_COPY_TO: begin
          rf_we = 1'b1; rf_waddr = ctrl.idx; rf_wdata = r1;
        end
        K_COPY_FROM: begin
          rf_we = 1'b1; rf_wdata = rf_rdata;
        end
        K_INC, K_DEC: rf_we = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      off_q   <= OFF_START;
      flag_q  <= 2'b00;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (ctrl.kind == K_JUMP) off_q <= ctrl.arg;
        else off_q <= triad_enc(wrap_add(triad_val(off_q), 1));
        if (ctrl.kind inside {K_INC, K_DEC, K_TEST}) flag_q <= alu_sign;
      end
    end
  end

  assign exec_o = phase_q;
  assign pc_o   = {seg, off_q};
  assign r1_o   = r1;
  assign flag_o = flag_q;
endmodule

// File: rtl/tern_exec_chk.sv
module tern_exec_chk
  import tern_pkg::*;
(
  input logic         clk_i,
  input logic         rst_ni,
  input logic         exec_i,
  input logic [11:0]  pc_i,
  input logic [5:0]   r1_i,
  input logic [1:0]   flag_i,
  input logic [9:0]   instr_i
);
  function automatic logic legal(triad_t x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < TRITS; i++) if (x[2*i +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  assert_exec_alternates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> !exec_i);

  assert_fetch_then_exec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> exec_i);

  assert_offset_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_val(instr_i) != OP_JUMP) |=>
      triad_val(pc_i[TW-1:0]) == wrap_add(triad_val($past(pc_i[TW-1:0])), 1));

  assert_jump_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_val(instr_i) == OP_JUMP) |=>
      (triad_val(pc_i[TW-1:0]) == triad_val($past(instr_i[TW-1:0])))
      && (pc_i[2*TW-1:TW] == $past(pc_i[2*TW-1:TW])));

  assert_test_keeps_r1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_val(instr_i) == 0 && triad_val(instr_i[TW-1:0]) == 0) |=>
      $stable(r1_i) && flag_i == trit_enc(triad_val(r1_i)));

  assert_nop_ops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_val(instr_i) inside {-1, -2, -4}) |=>
      $stable(r1_i) && $stable(flag_i) && $stable(pc_i[2*TW-1:TW]));

  // R11: loaded value is canonical
  assert_load_r1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_val(instr_i) == 1) |=>
      triad_val(r1_i) == triad_val($past(instr_i[TW-1:0])) && legal(r1_i));
endmodule

bind tern_exec tern_exec_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exec_i  (exec_o),
  .pc_i    (pc_o),
  .r1_i    (r1_o),
  .flag_i  (flag_o),
  .instr_i (instr_q)
);

// File: tb/tb_tern_exec.sv
module tb_tern_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [11:0] imem_addr = '0;
  logic [9:0]  imem_data = '0;
  logic        exec;
  logic [11:0] pc;
  logic [5:0]  r1;
  logic [1:0]  flag;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  logic cmp_en = 1'b0;

  tern_exec dut (
    .clk_i(clk), .rst_ni(rst_n), .imem_we_i(imem_we), .imem_addr_i(imem_addr),
    .imem_data_i(imem_data), .exec_o(exec), .pc_o(pc), .r1_o(r1), .flag_o(flag)
  );

  always #5 clk = ~clk;

  // encoding per R11
  function automatic int tv(logic [1:0] t);
    return (t == 2'b01) ? 1 : (t == 2'b10) ? -1 : 0;
  endfunction
  function automatic int triv(logic [5:0] x);
    return 9 * tv(x[5:4]) + 3 * tv(x[3:2]) + tv(x[1:0]);
  endfunction
  function automatic logic [1:0] et(int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b10 : 2'b00;
  endfunction
  function automatic logic [5:0] enc3(int v);
    int u = v + 13;
    logic [5:0] r;
    for (int i = 0; i < 3; i++) begin r[2*i +: 2] = et(u % 3 - 1); u = u / 3; end
    return r;
  endfunction
  function automatic int wr(int v);
    return (v > 13) ? v - 27 : (v < -13) ? v + 27 : v;
  endfunction
  function automatic logic [9:0] mk(int op, int k);
    int u = op + 4;
    return {et(u / 3 - 1), et(u % 3 - 1), enc3(k)};
  endfunction
  function automatic int lin(int s, int o);
    return (s + 13) * 27 + (o + 13);
  endfunction

  // reference model
  logic [9:0] mm [0:728];
  int rg [1:13];
  int mflag, moff, ph;
  logic [9:0] cur;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 13; i++) rg[i] = 0;
      mflag = 0; moff = -13; ph = 0;
    end else if (ph == 0) begin
      cur = mm[lin(rg[13], moff)];
      ph = 1;
    end else begin
      int op, k;
      bit jumped;
      op = 3 * tv(cur[9:8]) + tv(cur[7:6]);
      k = triv(cur[5:0]);
      jumped = 0;
      if (op >= 1) rg[op] = k;
      else if (op == 0) begin
        if (k <= -2) rg[-k] = rg[1];
        else if (k >= 2) rg[1] = rg[k];
        else if (k == 1) begin rg[1] = wr(rg[1] + 1); mflag = rg[1]; end
        else if (k == -1) begin rg[1] = wr(rg[1] - 1); mflag = rg[1]; end
        else mflag = rg[1];
      end else if (op == -3) begin
        moff = k; jumped = 1;
      end
      if (!jumped) moff = wr(moff + 1);
      ph = 0;
    end
  end

  task automatic chk(string tag, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && cmp_en) begin
      chk(cur_tag, "exec (R2)", {11'd0, exec}, {11'd0, ph == 1});
      chk(cur_tag, "r1", {6'd0, r1}, {6'd0, enc3(rg[1])});
      chk(cur_tag, "flag", {10'd0, flag}, {10'd0, et(mflag)});
      chk(cur_tag, "pc", pc, {enc3(rg[13]), enc3(moff)});
    end
  end

  int pseg, poff;

  task automatic put(int s, int o, logic [9:0] w);
    imem_we = 1'b1; imem_addr = {enc3(s), enc3(o)}; imem_data = w;
    mm[lin(s, o)] = w;
    @(negedge clk);
  endtask
  task automatic emit(int op, int k);
    put(pseg, poff, mk(op, k)); poff++;
  endtask
  task automatic emit_raw(logic [9:0] w);
    put(pseg, poff, w); poff++;
  endtask
  task automatic begin_prog();
    @(negedge clk);
    cmp_en = 1'b0; rst_n = 1'b0; pseg = 0; poff = -13;
  endtask
  task automatic run_prog(string tag, int n);
    imem_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: state right after reset release
    chk("R1", "reset r1", {6'd0, r1}, 12'd0);
    chk("R1", "reset flag", {10'd0, flag}, 12'd0);
    chk("R1", "reset pc", pc, {6'b000000, 6'b101010});
    chk("R1", "reset exec", {11'd0, exec}, 12'd0);
    cur_tag = tag; cmp_en = 1'b1;
    repeat (n) @(negedge clk);
    cmp_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: fill store with reserved no-ops
    for (int s = -13; s <= 13; s++)
      for (int o = -13; o <= 13; o++) put(s, o, mk(-4, 0));

    // loads, illegal codes, copy back
    begin_prog();
    emit(1, 5); emit(2, -7); emit(3, 13); emit(4, -13);
    emit_raw({2'b00, 2'b01, 6'b11_01_10});   // R11: param trit 11 as 0 -> +2
    emit_raw({2'b11, 2'b01, enc3(-4)});      // R11: opcode trit 11 as 0 -> load R1
    emit(0, 2); emit(0, 3); emit(0, 4);
    run_prog("R3 R11 R12", 30);

    // inc/dec wrap, test, copies
    begin_prog();
    emit(1, 13); emit(0, 1); emit(0, -1); emit(0, -1); emit(0, -5);
    emit(1, 0); emit(0, 0); emit(1, -3); emit(0, 0); emit(0, 5);
    emit(0, -12); emit(1, 1); emit(0, -1); emit(0, 12);
    emit(1, -6); emit(0, -7); emit(1, -13); emit(0, -1); emit(0, 7);
    run_prog("R4 R5 R6", 44);

    // no-ops, jump, offset wrap
    begin_prog();
    emit(1, 4); emit(-1, 3); emit(-2, -2); emit(-4, 1); emit(-3, 11);
    put(0, 11, mk(0, 1)); put(0, 12, mk(-1, 0)); put(0, 13, mk(0, 1));
    run_prog("R7 R8 R10", 40);

    // segment switch through register 13
    begin_prog();
    emit(1, 1); emit(0, -13);
    put(1, -11, mk(0, 13)); put(1, -10, mk(1, -1)); put(1, -9, mk(0, -13));
    put(-1, -8, mk(1, 9)); put(-1, -7, mk(0, 13)); put(-1, -6, mk(-3, -13));
    put(-1, -13, mk(1, 7));
    run_prog("R9 R12", 30);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule